// File: doc/BRIEF.md
# Shift Unit with Condition Code

This block is a shift and rotate stage for a 64-bit integer datapath. Each strobed request carries an operation code, an operand, a base register value with a flag telling whether a base register is named, and a 12-bit unsigned displacement. The shift distance is the low six bits of the computed address. The operation picks the direction, the kind (arithmetic, logical or rotate) and the width: a 32-bit word, a 64-bit word, or a register pair that is handled as one 64-bit value.

The arithmetic forms also produce a 2-bit condition code with a valid flag. The left arithmetic shift keeps its sign bit in place and reports overflow through a dedicated code value. The logical forms and the rotates raise no condition code, so the surrounding pipeline keeps the previous one. All results are registered and appear one cycle after the request. The result is also given as two 32-bit halves, which the caller uses to write back a register pair.

Top module: `shift_cc_unit`

## Requirements
- R1: The shift amount is bits [5:0] of (in_base + zero-extended in_disp) when in_base_en is 1, and bits [5:0] of in_disp when in_base_en is 0. In the second case in_base has no effect. The same 6-bit amount (0..63) applies at every width.
- R2: Operation codes on in_op: 0 SLA32, 1 SLA64, 2 SLAD, 3 SLL32, 4 SLL64, 5 SLLD, 6 SRA32, 7 SRA64, 8 SRAD, 9 SRL32, 10 SRL64, 11 SRLD, 12 ROL32, 13 ROL64. A request accepted with in_valid produces out_valid and its results on the next clock edge. After reset, out_valid, out_cc_valid and out_result are 0.
- R3: For the left arithmetic shift, the result's sign bit (bit 31 for SLA32, bit 63 otherwise) equals the operand's sign bit. The bits below it come from the operand shifted left, with zeros filling from the right. 32-bit results are zero-extended in out_result.
- R4: A left arithmetic shift gives condition code 3 when any bit that passes through the sign position differs from the sign bit. The 32-bit form is judged as if its operand sat in the upper half of a 64-bit word, so for amounts of 32 and above a negative operand always overflows and a positive one overflows unless it is zero.
- R5: Without overflow, the arithmetic forms give condition code 0 for a zero result, 1 for a negative result and 2 for a positive result. Sign and zero are judged at 32 bits for SLA32 and SRA32 and at 64 bits otherwise.
- R6: The right arithmetic shift fills with copies of the sign bit. SRA32 sign-extends from bit 31, and amounts of 32 to 63 give all sign bits in the low 32 bits.
- R7: The logical shifts fill with zeros. The 32-bit forms take the operand zero-extended from bit 31, and amounts of 32 to 63 give a zero result.
- R8: ROL32 rotates the low 32 bits left by the amount modulo 32. ROL64 rotates all 64 bits by the full 6-bit amount.
- R9: Logical shifts and rotates keep out_cc_valid at 0. Codes 14 and 15 give a zero result and out_cc_valid 0.
- R10: The pair forms (SLAD, SLLD, SRAD, SRLD) take in_opnd as {even register, odd register} and shift it as one 64-bit value. For every operation, out_hi equals out_result[63:32] and out_lo equals out_result[31:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| in_op | input | 4 | Operation code (R2) |
| in_opnd | input | 64 | Operand; for pair forms {even, odd} |
| in_base | input | 64 | Base register value |
| in_base_en | input | 1 | A base register is named |
| in_disp | input | 12 | Unsigned displacement |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| out_result | output | 64 | Shift or rotate result |
| out_hi | output | 32 | Upper half of the result (even register) |
| out_lo | output | 32 | Lower half of the result (odd register) |
| out_cc | output | 2 | Condition code |
| out_cc_valid | output | 1 | Condition code is defined for this result |

## Verification
The bench builds the unit with a 64-bit word and a 12-bit displacement. With these values every one of the 64 shift amounts can be reached from the displacement alone, while the displacement bits above bit 5 still carry random values that must be ignored. A 64-bit base added to a 12-bit displacement also reaches carries out of the low six bits, which checks that only the low six bits of the sum are used. At these widths the 32-bit forms meet amounts of 32 to 63, which is where the overflow rule judged in the upper half of the word and the zero or all-sign fill produce their distinctive results.

// File: rtl/shift_cc_pkg.sv
package shift_cc_pkg;
  parameter int unsigned WORD_W = 64;
  localparam int unsigned HALF_W = WORD_W / 2;
  localparam int unsigned AMT_W  = $clog2(WORD_W);

  typedef enum logic [3:0] {
    OP_SLA32 = 4'd0,  OP_SLA64 = 4'd1,  OP_SLAD = 4'd2,
    OP_SLL32 = 4'd3,  OP_SLL64 = 4'd4,  OP_SLLD = 4'd5,
    OP_SRA32 = 4'd6,  OP_SRA64 = 4'd7,  OP_SRAD = 4'd8,
    OP_SRL32 = 4'd9,  OP_SRL64 = 4'd10, OP_SRLD = 4'd11,
    OP_ROL32 = 4'd12, OP_ROL64 = 4'd13
  } shift_op_e;

  typedef enum logic [1:0] {
    CC_ZERO = 2'd0, CC_NEG = 2'd1, CC_POS = 2'd2, CC_OVF = 2'd3
  } cc_e;

  function automatic logic op_is_w32(shift_op_e op);
    return op inside {OP_SLA32, OP_SLL32, OP_SRA32, OP_SRL32, OP_ROL32};
  endfunction

  function automatic logic op_is_sla(shift_op_e op);
    return op inside {OP_SLA32, OP_SLA64, OP_SLAD};
  endfunction

  function automatic logic op_is_arith(shift_op_e op);
    return op inside {OP_SLA32, OP_SLA64, OP_SLAD, OP_SRA32, OP_SRA64, OP_SRAD};
  endfunction

  // Bits from the sign position down through n positions below it must all
  // equal the sign bit, otherwise a left arithmetic shift by n overflows.
  function automatic logic sla_overflow(logic [WORD_W-1:0] x, logic [AMT_W-1:0] n);
    logic [WORD_W-1:0] mask;
    mask = {WORD_W{1'b1}} << (AMT_W'(WORD_W - 1) - n);
    return (x & mask) != (x[WORD_W-1] ? mask : '0);
  endfunction
endpackage

// File: rtl/shamt_gen.sv
module shamt_gen
  import shift_cc_pkg::*;
#(
  parameter int unsigned DISP_W = 12
) (
  input  logic [WORD_W-1:0] base,
  input  logic              base_en,
  input  logic [DISP_W-1:0] disp,
  output logic [AMT_W-1:0]  amt
);
  logic [WORD_W-1:0] disp_ext;
  logic [WORD_W-1:0] addr;
  logic              unused_addr_hi;

  assign disp_ext       = {{(WORD_W-DISP_W){1'b0}}, disp};
  assign addr           = base_en ? (base + disp_ext) : disp_ext;
  assign amt            = addr[AMT_W-1:0];
  assign unused_addr_hi = ^addr[WORD_W-1:AMT_W];
endmodule

// File: rtl/shift_core.sv
module shift_core
  import shift_cc_pkg::*;
(
  input  shift_op_e         op,
  input  logic [WORD_W-1:0] opnd,
  input  logic [AMT_W-1:0]  amt,
  output logic [WORD_W-1:0] result,
  output logic              sla_ovf
);
  localparam logic [HALF_W-1:0] ZERO_HALF = '0;

  logic [HALF_W-1:0]   lo_word;
  logic                w32;
  logic [WORD_W-1:0]   src;
  logic [WORD_W-1:0]   ovf_src;
  logic [WORD_W-1:0]   shl;
  logic [WORD_W-1:0]   shr_l;
  logic [WORD_W-1:0]   shr_a;
  logic [WORD_W-1:0]   rot_half;
  logic [2*WORD_W-1:0] rot_full;

  assign lo_word = opnd[HALF_W-1:0];
  assign w32     = op_is_w32(op);

  always_comb begin
    if (!w32)
      src = opnd;
    else if (op == OP_SRA32)
      src = {{HALF_W{lo_word[HALF_W-1]}}, lo_word};
    else
      src = {ZERO_HALF, lo_word};
  end

  assign ovf_src  = w32 ? {lo_word, ZERO_HALF} : opnd;
  assign sla_ovf  = op_is_sla(op) && sla_overflow(ovf_src, amt);
  assign shl      = src << amt;
  assign shr_l    = src >> amt;
  assign shr_a    = $signed(src) >>> amt;
  assign rot_half = {lo_word, lo_word} << amt[AMT_W-2:0];
  assign rot_full = {opnd, opnd} << amt;

  always_comb begin
    case (op)
      OP_SLA32:                   result = {ZERO_HALF, lo_word[HALF_W-1], shl[HALF_W-2:0]};
      OP_SLA64, OP_SLAD:          result = {opnd[WORD_W-1], shl[WORD_W-2:0]};
      OP_SLL32:                   result = {ZERO_HALF, shl[HALF_W-1:0]};
      OP_SLL64, OP_SLLD:          result = shl;
      OP_SRA32:                   result = {ZERO_HALF, shr_a[HALF_W-1:0]};
      OP_SRA64, OP_SRAD:          result = shr_a;
      OP_SRL32:                   result = {ZERO_HALF, shr_l[HALF_W-1:0]};
      OP_SRL64, OP_SRLD:          result = shr_l;
      OP_ROL32:                   result = {ZERO_HALF, rot_half[WORD_W-1:HALF_W]};
      OP_ROL64:                   result = rot_full[2*WORD_W-1:WORD_W];
      default:                    result = '0;
    endcase
  end
endmodule

// File: rtl/cc_gen.sv
module cc_gen
  import shift_cc_pkg::*;
(
  input  shift_op_e         op,
  input  logic [WORD_W-1:0] result,
  input  logic              sla_ovf,
  output cc_e               cc,
  output logic              cc_valid
);
  logic w32;
  logic is_neg;
  logic is_zero;

  assign w32      = op_is_w32(op);
  assign is_neg   = w32 ? result[HALF_W-1] : result[WORD_W-1];
  assign is_zero  = w32 ? (result[HALF_W-1:0] == '0) : (result == '0);
  assign cc_valid = op_is_arith(op);

  always_comb begin
    if (sla_ovf)      cc = CC_OVF;
    else if (is_zero) cc = CC_ZERO;
    else if (is_neg)  cc = CC_NEG;
    else              cc = CC_POS;
  end
endmodule

// File: rtl/shift_cc_unit.sv
module shift_cc_unit
  import shift_cc_pkg::*;
#(
  parameter int unsigned DISP_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [3:0]        in_op,
  input  logic [WORD_W-1:0] in_opnd,
  input  logic [WORD_W-1:0] in_base,
  input  logic              in_base_en,
  input  logic [DISP_W-1:0] in_disp,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_result,
  output logic [HALF_W-1:0] out_hi,
  output logic [HALF_W-1:0] out_lo,
  output logic [1:0]        out_cc,
  output logic              out_cc_valid
);
  shift_op_e         op_in;
  logic [AMT_W-1:0]  amt;
  logic [WORD_W-1:0] core_result;
  logic              sla_ovf;
  cc_e               cc_next;
  logic              cc_valid_next;

  shift_op_e         op_q;
  logic              valid_q;
  logic [WORD_W-1:0] result_q;
  cc_e               cc_q;
  logic              ccv_q;

  assign op_in = shift_op_e'(in_op);

  shamt_gen #(.DISP_W(DISP_W)) u_amt (
    .base(in_base), .base_en(in_base_en), .disp(in_disp), .amt(amt)
  );

  shift_core u_core (
    .op(op_in), .opnd(in_opnd), .amt(amt), .result(core_result), .sla_ovf(sla_ovf)
  );

  cc_gen u_cc (
    .op(op_in), .result(core_result), .sla_ovf(sla_ovf),
    .cc(cc_next), .cc_valid(cc_valid_next)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q  <= 1'b0;
      op_q     <= OP_SLA32;
      result_q <= '0;
      cc_q     <= CC_ZERO;
      ccv_q    <= 1'b0;
    end else begin
      valid_q <= in_valid;
      if (in_valid) begin
        op_q     <= op_in;
        result_q <= core_result;
        cc_q     <= cc_next;
        ccv_q    <= cc_valid_next;
      end else begin
        ccv_q    <= 1'b0;
      end
    end
  end

  assign out_valid    = valid_q;
  assign out_result   = result_q;
  assign out_hi       = result_q[WORD_W-1:HALF_W];
  assign out_lo       = result_q[HALF_W-1:0];
  assign out_cc       = cc_q;
  assign out_cc_valid = ccv_q;

  a_r2_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  a_r1_disp_only: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !in_base_en && op_in == OP_ROL64 && in_disp[AMT_W-1:0] == '0
    |=> out_result == $past(in_opnd));

  a_r3_sign_kept: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && op_in == OP_SLA64 |=> out_result[WORD_W-1] == $past(in_opnd[WORD_W-1]));

  a_r4_ovf_only_sla: assert property (@(posedge clk) disable iff (!rst_n)
    out_cc_valid && out_cc == CC_OVF |-> op_is_sla(op_q));

  a_r5_zero_code: assert property (@(posedge clk) disable iff (!rst_n)
    out_cc_valid && out_cc != CC_OVF && !op_is_w32(op_q) && out_result == '0
    |-> out_cc == CC_ZERO);

  a_r6_sign_fill: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && op_in == OP_SRA64 && in_opnd[WORD_W-1] |=> out_result[WORD_W-1]);

  a_r9_no_cc_logical: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !op_is_arith(op_in) |=> !out_cc_valid);
endmodule

// File: tb/shift_cc_unit_tb.sv
`timescale 1ns/1ps
module shift_cc_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [3:0]  in_op = '0;
  logic [63:0] in_opnd = '0;
  logic [63:0] in_base = '0;
  logic        in_base_en = 1'b0;
  logic [11:0] in_disp = '0;
  logic        out_valid;
  logic [63:0] out_result;
  logic [31:0] out_hi;
  logic [31:0] out_lo;
  logic [1:0]  out_cc;
  logic        out_cc_valid;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  logic [63:0] q_res[$];
  logic [1:0]  q_cc[$];
  bit          q_ccv[$];
  int          q_op[$];
  string       q_tag[$];

  always #2.5 clk = ~clk;

  shift_cc_unit u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
    .in_opnd(in_opnd), .in_base(in_base), .in_base_en(in_base_en),
    .in_disp(in_disp), .out_valid(out_valid), .out_result(out_result),
    .out_hi(out_hi), .out_lo(out_lo), .out_cc(out_cc), .out_cc_valid(out_cc_valid)
  );

  // Reference: one bit position per step, restated from the requirements.
  function automatic void ref_calc(input int op, input logic [63:0] a, input int n,
                                   output logic [63:0] r, output logic [1:0] cc,
                                   output bit ccv);
    int w;
    int k;
    bit s;
    bit ovf;
    bit b;
    logic [63:0] v;
    r = '0; cc = 2'd0; ccv = 1'b0; ovf = 1'b0;
    if (op > 13) return;                       // R9 undefined codes
    w = ((op % 3 == 0) && op != 13) ? 32 : 64;
    v = (w == 32) ? {32'b0, a[31:0]} : a;
    s = v[w-1];
    case (op / 3)
      0: for (int i = 0; i < n; i++) begin    // R3 R4
           if (v[w-2] != s) ovf = 1'b1;
           v = v << 1; v[w-1] = s;
           if (w == 32) v[63:32] = '0;
         end
      1: for (int i = 0; i < n; i++) begin    // R7
           v = v << 1;
           if (w == 32) v[63:32] = '0;
         end
      2: for (int i = 0; i < n; i++) begin    // R6
           v = v >> 1; v[w-1] = s;
         end
      3: for (int i = 0; i < n; i++) v = v >> 1;
      default: begin                          // R8
           k = (w == 32) ? n % 32 : n;
           for (int i = 0; i < k; i++) begin
             b = v[w-1]; v = v << 1; v[0] = b;
             if (w == 32) v[63:32] = '0;
           end
         end
    endcase
    r = v;
    if (op / 3 == 0 || op / 3 == 2) begin     // R5
      ccv = 1'b1;
      if (ovf) cc = 2'd3;
      else if (v == '0) cc = 2'd0;
      else if (v[w-1]) cc = 2'd1;
      else cc = 2'd2;
    end
  endfunction

  function automatic string tag_of(input int op, input bit be);
    string t;
    if (op > 13) t = "R9";
    else case (op / 3)
      0: t = "R3 R4 R5";
      1: t = "R7 R9";
      2: t = "R6 R5";
      3: t = "R7 R9";
      default: t = "R8 R9";
    endcase
    if (op < 12 && op % 3 == 2) t = {t, " R10"};
    if (be) t = {t, " R1"};
    return {t, " R2"};
  endfunction

  task automatic send(input int op, input logic [63:0] a, input logic [63:0] b,
                      input bit be, input logic [11:0] d);
    logic [63:0] ea;
    logic [63:0] r;
    logic [1:0]  cc;
    bit          ccv;
    ea = be ? b + {52'b0, d} : {52'b0, d};
    ref_calc(op, a, int'(ea[5:0]), r, cc, ccv);
    q_res.push_back(r); q_cc.push_back(cc); q_ccv.push_back(ccv);
    q_op.push_back(op); q_tag.push_back(tag_of(op, be));
    @(negedge clk);
    in_valid = 1'b1; in_op = 4'(op); in_opnd = a;
    in_base = b; in_base_en = be; in_disp = d;
  endtask

  function automatic logic [63:0] rnd64();
    return {$urandom(), $urandom()};
  endfunction

  // Monitor: pops the scoreboard as results appear.
  initial begin
    forever begin
      @(negedge clk); #1;
      if (rst_n && out_valid && !done) begin
        n_tests++;
        if (q_res.size() == 0) begin
          n_fail++;
          $display("FAIL R2 unexpected out_valid result=%h expected no output", out_result);
        end else begin
          logic [63:0] er; logic [1:0] ec; bit ev; int eo; string et;
          er = q_res.pop_front(); ec = q_cc.pop_front(); ev = q_ccv.pop_front();
          eo = q_op.pop_front(); et = q_tag.pop_front();
          if (out_result !== er || {out_hi, out_lo} !== er || out_cc_valid !== ev ||
              (ev && out_cc !== ec)) begin
            n_fail++;
            $display("FAIL %s op=%0d result=%h hi=%h lo=%h cc=%0d ccv=%0b expected result=%h cc=%0d ccv=%0b",
                     et, eo, out_result, out_hi, out_lo, out_cc, out_cc_valid, er, ec, ev);
          end
        end
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_tests++; n_fail++;
      $display("FAIL R2 watchdog expired actual=hung expected=complete");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [63:0] corner [6];
    int amts [8];
    corner = '{64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0000,
               64'h7FFF_FFFF_FFFF_FFFF, 64'h0000_0000_8000_0000, 64'h4000_0000_4000_0001};
    amts = '{0, 1, 30, 31, 32, 33, 62, 63};

    repeat (3) @(negedge clk);
    // R2 reset state
    n_tests++;
    if (out_valid !== 1'b0 || out_cc_valid !== 1'b0 || out_result !== 64'h0) begin
      n_fail++;
      $display("FAIL R2 reset valid=%0b ccv=%0b result=%h expected 0 0 0",
               out_valid, out_cc_valid, out_result);
    end
    rst_n = 1'b1;
    @(negedge clk);

    // Every operation across all 64 amounts; base ignored (R1), upper disp bits random.
    for (int op = 0; op < 14; op++)
      for (int n = 0; n < 64; n++)
        send(op, rnd64(), rnd64(), 1'b0, 12'(n + 64 * $urandom_range(0, 63)));

    // Corner operands at the overflow and fill boundaries (R4 R6 R7 R8).
    for (int op = 0; op < 14; op++)
      for (int c = 0; c < 6; c++)
        for (int k = 0; k < 8; k++)
          send(op, corner[c], 64'h0, 1'b0, 12'(amts[k]));

    // Base plus displacement, including carries out of the low six bits (R1).
    for (int i = 0; i < 300; i++)
      send($urandom_range(0, 13), rnd64(), rnd64(), 1'b1, 12'($urandom()));

    // Undefined operation codes (R9).
    for (int i = 0; i < 8; i++)
      send(14 + (i % 2), rnd64(), rnd64(), i[0], 12'($urandom()));

    @(negedge clk);
    in_valid = 1'b0;
    repeat (4) @(negedge clk);

    // R2: every request answered exactly once.
    n_tests++;
    if (q_res.size() != 0) begin
      n_fail++;
      $display("FAIL R2 pending results actual=%0d expected=0", q_res.size());
    end

    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule